// File: doc/BRIEF.md
# Strobe-Windowed Gated One-of-Eight Decoder

This block turns a 3-bit selection code into a one-hot set of eight outputs. An output is driven only inside a time window that two strobe inputs define. A falling edge on the open strobe starts the window, and a falling edge on the close strobe ends it. A chip-enable input gates the result as well. In a processor I/O system the two strobes carry the two timing pulses of each machine cycle, with the open pulse first, and the selection code carries the I/O command number. The decoded line then strobes one peripheral port for the part of the cycle between the two pulses.

The strobes are asynchronous to the block's clock. Each one passes through a synchronizer chain, and its falling edge is detected on the synchronized level. A single window flag records whether the window is open. The final one-hot word is registered. Because the chip-enable input gates every output, one decoder's output can drive the chip enable of a second-level decoder to build multilevel decoding.

Top module: `gated_strobe_decoder`

## Requirements
- R1: Selection code k (bit 0 of `sel` is the least significant) drives bit k of `dec_out` high and all other bits low while the window is open and `chip_en` is high. Code 0 maps to bit 0 and code 7 to bit 7.
- R2: A high-to-low change on `strobe_open` opens the window. With `chip_en` high, the selected output rises on the third rising clock edge after the first edge that samples the low level.
- R3: A high-to-low change on `strobe_close` closes the window with the same latency as R2. While the window is closed all outputs are low, even with `chip_en` high.
- R4: Steady strobe levels and low-to-high strobe changes leave the window state unchanged.
- R5: `chip_en` sampled low forces all outputs low on the next clock edge, whatever `sel` and the strobes are doing. Raising it again inside an open window restores the decoded output on the next edge.
- R6: If both strobes fall so that both edges are detected in the same clock cycle, the close edge wins and the window ends closed.
- R7: A change of `sel` inside an open window moves the active output to the new code on the next clock edge.
- R8: Asserting `arst_n` low clears all outputs at once and closes the window. A strobe held low across reset release is not counted as a falling edge.
- R9: At no time is more than one bit of `dec_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel | input | 3 | Selection code (SEL_W bits) |
| chip_en | input | 1 | Active-high gate for all outputs |
| strobe_open | input | 1 | Asynchronous strobe; its falling edge opens the window |
| strobe_close | input | 1 | Asynchronous strobe; its falling edge closes the window |
| dec_out | output | 8 | Registered one-hot decoded outputs (2**SEL_W bits) |

## Verification
The bench drives both strobes to fall together while the window is open. A design that let the open edge win would keep an output high after that cycle. It raises the strobes again inside an open window to catch logic that treats any level change as an edge. It also holds the open strobe low across a reset release: a synchronizer that reset to a high level would see a false falling edge and open the window with no strobe activity. Sweeps of the selection code to 0 and 7, and toggles of chip enable inside the window, expose bit-order mistakes and chip-enable gating that acts a cycle late or not at all.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

  // Action applied to the window flag in one clock cycle
  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_OPEN  = 2'd1,
    WIN_CLOSE = 2'd2
  } win_cmd_e;

  // Close has priority over open when both edges land together
  function automatic win_cmd_e win_cmd_of(input logic open_edge, input logic close_edge);
    if (close_edge)     return WIN_CLOSE;
    else if (open_edge) return WIN_OPEN;
    else                return WIN_HOLD;
  endfunction

endpackage

// File: rtl/gsd_rst_sync.sv
module gsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] rst_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb rst_d = 1'b1;
    end else begin : g_chain
      always_comb rst_d = {rst_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= rst_d;
  end

  assign rst_n_o = rst_q[STAGES-1];

endmodule

// File: rtl/gsd_fall_detect.sv
module gsd_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = strobe_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], strobe_i};
    end
  endgenerate

  assign synced = sync_q[STAGES-1];

  always_comb last_d = synced;

  // Reset to low: a strobe resting low at release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_o = last_q & ~synced;

endmodule

// File: rtl/gsd_window.sv
module gsd_window
  import gsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic open_edge_i,
  input  logic close_edge_i,
  output logic open_o
);

  win_cmd_e cmd;
  logic     flag_q;
  logic     flag_d;
  logic     flag_en;

  always_comb begin
    cmd     = win_cmd_of(open_edge_i, close_edge_i);
    flag_en = (cmd != WIN_HOLD);
    unique case (cmd)
      WIN_OPEN:  flag_d = 1'b1;
      WIN_CLOSE: flag_d = 1'b0;
      default:   flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign open_o = flag_q;

endmodule

// File: rtl/gsd_onehot.sv
module gsd_onehot #(
  parameter int SEL_W   = 3,
  parameter int NUM_OUT = 1 << SEL_W
) (
  input  logic               en_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_OUT-1:0] hot_o
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
    assign hot_o[i] = en_i && (sel_i == SEL_W'(i));
  end

endmodule

// File: rtl/gated_strobe_decoder.sv
module gated_strobe_decoder #(
  parameter  int SEL_W       = 3,
  parameter  int SYNC_STAGES = 2,
  parameter  int RST_STAGES  = 2,
  localparam int NUM_OUT     = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               chip_en,
  input  logic               strobe_open,
  input  logic               strobe_close,
  output logic [NUM_OUT-1:0] dec_out
);

  logic               rst_n;
  logic               fall_open;
  logic               fall_close;
  logic               win_open;
  logic               gate;
  logic [NUM_OUT-1:0] hot;
  logic [NUM_OUT-1:0] out_q;
  logic [NUM_OUT-1:0] out_d;
  logic               out_en;

  gsd_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  gsd_fall_detect #(.STAGES(SYNC_STAGES)) i_open_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_open),
    .fall_o   (fall_open)
  );

  gsd_fall_detect #(.STAGES(SYNC_STAGES)) i_close_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_close),
    .fall_o   (fall_close)
  );

  gsd_window i_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .open_edge_i  (fall_open),
    .close_edge_i (fall_close),
    .open_o       (win_open)
  );

  assign gate = win_open & chip_en;

  gsd_onehot #(.SEL_W(SEL_W), .NUM_OUT(NUM_OUT)) i_onehot (
    .en_i  (gate),
    .sel_i (sel),
    .hot_o (hot)
  );

  always_comb begin
    out_d  = hot;
    out_en = (out_d != out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign dec_out = out_q;

endmodule

// File: rtl/gsd_checker.sv
module gsd_checker #(
  parameter  int SEL_W   = 3,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   sel,
  input logic               chip_en,
  input logic               win_open,
  input logic               fall_open,
  input logic               fall_close,
  input logic [NUM_OUT-1:0] dec_out
);

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dec_out)); // R9
  AST_CE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !chip_en |=> (dec_out == '0)); // R5
  AST_SELECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (chip_en && win_open) |=> (dec_out == (NUM_OUT'(1) << $past(sel)))); // R1
  AST_CLOSED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !win_open |=> (dec_out == '0)); // R3
  AST_OPEN_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (fall_open && !fall_close) |=> win_open); // R2
  AST_CLOSE_WINS: assert property (@(posedge clk) disable iff (!rst_n) fall_close |=> !win_open); // R6
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (!fall_open && !fall_close) |=> $stable(win_open)); // R4

endmodule

bind gated_strobe_decoder gsd_checker #(.SEL_W(SEL_W)) i_gsd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .chip_en    (chip_en),
  .win_open   (win_open),
  .fall_open  (fall_open),
  .fall_close (fall_close),
  .dec_out    (dec_out)
);

// File: tb/test_gated_strobe_decoder.sv
`timescale 1ns/1ps
module test_gated_strobe_decoder;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [2:0] sel = '0;
  logic       chip_en = 1'b0;
  logic       strobe_open = 1'b0;
  logic       strobe_close = 1'b0;
  logic [7:0] dec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int prev_tag = 8;

  always #2.5 clk = ~clk;

  gated_strobe_decoder i_gated_strobe_decoder (
    .clk          (clk),
    .arst_n       (arst_n),
    .sel          (sel),
    .chip_en      (chip_en),
    .strobe_open  (strobe_open),
    .strobe_close (strobe_close),
    .dec_out      (dec_out)
  );

  // Reference model: an edge is seen when the sample three edges back is
  // high and the one two edges back is low; close beats open; the output
  // register adds one more edge.
  logic [2:0] ha, hb;
  logic       mflag;
  logic [7:0] exp_out;
  always @(posedge clk or negedge arst_n) begin
    logic fa, fb;
    if (!arst_n) begin
      ha <= '0; hb <= '0; mflag <= 1'b0; exp_out <= '0;
    end else begin
      fa = ha[2] & ~ha[1];
      fb = hb[2] & ~hb[1];
      exp_out <= (mflag && chip_en) ? (8'd1 << sel) : 8'd0;
      mflag   <= fb ? 1'b0 : (fa ? 1'b1 : mflag);
      ha <= {ha[1:0], strobe_open};
      hb <= {hb[1:0], strobe_close};
    end
  end

  task automatic check(input int tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: dec_out actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Row: [9:6] tag, [5] chip_en, [4:2] sel, [1] strobe_open, [0] strobe_close
  task automatic step(input logic [9:0] row);
    @(negedge clk);
    check(prev_tag, dec_out, exp_out);
    checks++;
    if ($countones(dec_out) > 1) begin // R9
      fails++;
      $display("FAIL R9: dec_out actual %b expected at most one bit set", dec_out);
    end
    prev_tag     = int'(row[9:6]);
    chip_en      = row[5];
    sel          = row[4:2];
    strobe_open  = row[1];
    strobe_close = row[0];
  endtask

  localparam int NROWS = 33;
  localparam logic [9:0] ROWS [NROWS] = '{
    {4'd4, 1'b1, 3'd0, 1'b1, 1'b1}, // R4 strobes rise, window stays shut
    {4'd4, 1'b1, 3'd0, 1'b1, 1'b1},
    {4'd4, 1'b1, 3'd0, 1'b1, 1'b1},
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b1}, // R2 open strobe falls
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b1},
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b1},
    {4'd2, 1'b1, 3'd3, 1'b0, 1'b1},
    {4'd1, 1'b1, 3'd0, 1'b0, 1'b1}, // R1 lowest code
    {4'd1, 1'b1, 3'd7, 1'b0, 1'b1}, // R1 highest code
    {4'd7, 1'b1, 3'd5, 1'b0, 1'b1}, // R7 code moves inside window
    {4'd7, 1'b1, 3'd2, 1'b0, 1'b1},
    {4'd5, 1'b0, 3'd2, 1'b0, 1'b1}, // R5 chip enable low
    {4'd5, 1'b0, 3'd2, 1'b0, 1'b1},
    {4'd5, 1'b1, 3'd2, 1'b0, 1'b1}, // R5 chip enable back
    {4'd4, 1'b1, 3'd6, 1'b1, 1'b1}, // R4 open strobe rises, no effect
    {4'd4, 1'b1, 3'd6, 1'b1, 1'b1},
    {4'd4, 1'b1, 3'd6, 1'b1, 1'b1},
    {4'd4, 1'b1, 3'd6, 1'b1, 1'b1},
    {4'd3, 1'b1, 3'd4, 1'b1, 1'b0}, // R3 close strobe falls
    {4'd3, 1'b1, 3'd4, 1'b1, 1'b0},
    {4'd3, 1'b1, 3'd4, 1'b1, 1'b0},
    {4'd3, 1'b1, 3'd4, 1'b1, 1'b0},
    {4'd3, 1'b1, 3'd1, 1'b1, 1'b1},
    {4'd4, 1'b1, 3'd1, 1'b1, 1'b1},
    {4'd2, 1'b1, 3'd1, 1'b0, 1'b1}, // R2 reopen
    {4'd2, 1'b1, 3'd1, 1'b0, 1'b1},
    {4'd2, 1'b1, 3'd1, 1'b0, 1'b1},
    {4'd2, 1'b1, 3'd1, 1'b1, 1'b1},
    {4'd6, 1'b1, 3'd6, 1'b0, 1'b0}, // R6 both strobes fall together
    {4'd6, 1'b1, 3'd6, 1'b0, 1'b0},
    {4'd6, 1'b1, 3'd6, 1'b0, 1'b0},
    {4'd6, 1'b1, 3'd6, 1'b0, 1'b0},
    {4'd6, 1'b1, 3'd6, 1'b0, 1'b0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check(8, dec_out, 8'd0);
    arst_n = 1'b1;
    repeat (4) step({4'd8, 1'b0, 3'd0, 1'b0, 1'b0});

    for (int i = 0; i < NROWS; i++) step(ROWS[i]);
    repeat (5) step({4'd6, 1'b1, 3'd6, 1'b0, 1'b0});

    // Reopen, then reset in the middle of the window
    repeat (3) step({4'd2, 1'b1, 3'd7, 1'b1, 1'b1});
    repeat (5) step({4'd2, 1'b1, 3'd7, 1'b0, 1'b1});
    check(2, dec_out, 8'h80);
    @(negedge clk);
    arst_n = 1'b0;
    #1;
    check(8, dec_out, 8'd0); // R8 immediate clear
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    // R8 strobe held low across release must not open the window
    repeat (8) step({4'd8, 1'b1, 3'd7, 1'b0, 1'b1});
    check(8, dec_out, 8'd0);
    finish_run();
  end

endmodule